// File: doc/BRIEF.md
# Asynchronous Host Register Port with Vector Acknowledge

This block lets an external host processor see a small bank of 8-bit registers as if it were static RAM. The host presents a 3-bit register address and a read/write select, then pulses an active-low enable strobe. A write lands in the addressed register when the strobe returns high. A read drives the addressed register onto the host data bus once the strobe has gone low. The strobe is asynchronous to the block clock, so it is brought through a two-flop synchronizer, and both of its edges are found in the internal clock domain.

The internal core drives a request line toward the host's maskable interrupt input. The core sets and clears this line through two control pulses. When the host answers with its active-low acknowledge while the request is high, the block places its vector register on the bus in place of any addressed register. When that acknowledge ends, the request clears. The core sees every register continuously through flat output buses.

The bus is modelled as a data output with a separate output enable. Addresses 0 to 4 are general registers. Address 7 is the vector register. Addresses 5 and 6 are not implemented.

Top module: `host_reg_port`

## Requirements
- R1: After reset the output enable, the request line and every general register are 0, and the vector register holds 8'h0F.
- R2: In a write cycle (select = 0), the register at the address latched when the enable fell takes the host data present in the third clock edge after the enable returns high. The core bus shows the new value after that edge, and no register changes earlier.
- R3: In a read cycle (select = 1), the output enable rises in the third clock edge after the enable falls. While it is high, the data output carries the addressed general register.
- R4: The output enable drops in the third clock edge after the enable rises. It is never raised during a write cycle. While it is low, the data output is 0.
- R5: The vector register sits at address 7. The host can write it and read it back through ordinary cycles, and the core sees it on its own bus.
- R6: When the acknowledge falls while the request is high and no host cycle is open, the output enable rises in the third edge after the fall. The data output then carries the vector register. The output enable drops in the third edge after the acknowledge rises.
- R7: A core set pulse raises the request at the next edge. A core clear pulse lowers it at the next edge. When both pulses arrive together, the clear wins.
- R8: The request clears in the same edge in which a vector cycle's output enable drops.
- R9: Writes to addresses 5 and 6 change no register. Reads from them return 0 with the output enable high.
- R10: An acknowledge while the request is low never raises the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 3 | Host register address |
| host_rnw_i | input | 1 | Transfer direction, 1 = read, 0 = write |
| host_en_ni | input | 1 | Host access strobe, active low, asynchronous |
| host_ack_ni | input | 1 | Host interrupt acknowledge, active low, asynchronous |
| host_data_i | input | 8 | Write data from host |
| host_data_o | output | 8 | Read data toward host |
| host_data_oe_o | output | 1 | Host bus output enable |
| host_req_o | output | 1 | Service request toward host interrupt input |
| core_req_set_i | input | 1 | Core pulse that raises the request |
| core_req_clr_i | input | 1 | Core pulse that lowers the request |
| core_regs_o | output | 40 | General registers, register n at bits 8n+7:8n |
| core_vec_o | output | 8 | Vector register contents |

## Verification
Every strobe edge driven by the host takes effect three clock edges after it is applied. One edge passes through each synchronizer flop, and one more registers the detected edge. Core set and clear pulses take effect one edge after they are applied. The bench holds a behavioural model that keeps a four-deep history of each strobe, sampled on every rising edge. The model acts on the strobe value seen two and three edges back, so its expectations shift by exactly that latency. The bench drives inputs on the falling edge and compares bus, enable, request and core buses on every falling edge, half a period after the edge that should have changed them.

// File: rtl/host_port_pkg.sv
package host_port_pkg;
  localparam int unsigned HP_ADDR_W = 3;
  localparam int unsigned HP_DATA_W = 8;

  typedef logic [HP_ADDR_W-1:0] hp_addr_t;
  typedef logic [HP_DATA_W-1:0] hp_data_t;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_VEC   = 2'd3
  } cyc_e;
endpackage

// File: rtl/hp_strobe_sync.sv
module hp_strobe_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/hp_cycle_ctrl.sv
module hp_cycle_ctrl
  import host_port_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_fall_i,
  input  logic     en_rise_i,
  input  logic     ack_fall_i,
  input  logic     ack_rise_i,
  input  hp_addr_t addr_i,
  input  logic     rnw_i,
  input  hp_data_t data_i,
  input  logic     req_set_i,
  input  logic     req_clr_i,
  output cyc_e     cyc_o,
  output logic     oe_o,
  output hp_addr_t sel_addr_o,
  output logic     wr_en_o,
  output hp_addr_t wr_addr_o,
  output hp_data_t wr_data_o,
  output logic     vec_done_o,
  output logic     req_o
);
  cyc_e     cyc_q, cyc_d;
  logic     oe_q, oe_d;
  hp_addr_t addr_q, addr_d;
  logic     req_q;

  always_comb begin
    cyc_d  = cyc_q;
    oe_d   = oe_q;
    addr_d = addr_q;
    unique case (cyc_q)
      CYC_IDLE: begin
        // acknowledge with a pending request outranks a new access
        if (ack_fall_i && req_q) begin
          cyc_d = CYC_VEC;
          oe_d  = 1'b1;
        end else if (en_fall_i) begin
          addr_d = addr_i;
          cyc_d  = rnw_i ? CYC_READ : CYC_WRITE;
          oe_d   = rnw_i;
        end
      end
      CYC_READ: if (en_rise_i) begin
        cyc_d = CYC_IDLE;
        oe_d  = 1'b0;
      end
      CYC_WRITE: if (en_rise_i) cyc_d = CYC_IDLE;
      CYC_VEC: if (ack_rise_i) begin
        cyc_d = CYC_IDLE;
        oe_d  = 1'b0;
      end
      default: begin
        cyc_d = CYC_IDLE;
        oe_d  = 1'b0;
      end
    endcase
  end

  assign wr_en_o    = (cyc_q == CYC_WRITE) && en_rise_i;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_i;
  assign vec_done_o = (cyc_q == CYC_VEC) && ack_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= CYC_IDLE;
      oe_q   <= 1'b0;
      addr_q <= '0;
      req_q  <= 1'b0;
    end else begin
      cyc_q  <= cyc_d;
      oe_q   <= oe_d;
      addr_q <= addr_d;
      req_q  <= (req_q | req_set_i) & ~(req_clr_i | vec_done_o);
    end
  end

  assign cyc_o      = cyc_q;
  assign oe_o       = oe_q;
  assign sel_addr_o = addr_q;
  assign req_o      = req_q;
endmodule

// File: rtl/hp_reg_bank.sv
module hp_reg_bank
  import host_port_pkg::*;
#(
  parameter int unsigned NUM_GP   = 5,
  parameter hp_addr_t    VEC_ADDR = 3'd7,
  parameter hp_data_t    VEC_RST  = 8'h0F,
  localparam int unsigned FLAT_W  = NUM_GP * HP_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  hp_addr_t          wr_addr_i,
  input  hp_data_t          wr_data_i,
  input  hp_addr_t          rd_addr_i,
  output hp_data_t          rd_data_o,
  output logic [FLAT_W-1:0] regs_o,
  output hp_data_t          vec_o
);
  hp_data_t gp_q [NUM_GP];
  hp_data_t vec_q;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    gp_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == hp_addr_t'(g)) gp_q[g] <= wr_data_i;
    end
    assign regs_o[g*HP_DATA_W +: HP_DATA_W] = gp_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               vec_q <= VEC_RST;
    else if (wr_en_i && wr_addr_i == VEC_ADDR) vec_q <= wr_data_i;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_GP; i++)
      if (rd_addr_i == hp_addr_t'(i)) rd_data_o = gp_q[i];
    if (rd_addr_i == VEC_ADDR) rd_data_o = vec_q;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import host_port_pkg::*;
#(
  parameter int unsigned NUM_GP      = 5,
  parameter hp_addr_t    VEC_ADDR    = 3'd7,
  parameter hp_data_t    VEC_RST     = 8'h0F,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FLAT_W     = NUM_GP * HP_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        host_addr_i,
  input  logic              host_rnw_i,
  input  logic              host_en_ni,
  input  logic              host_ack_ni,
  input  logic [7:0]        host_data_i,
  output logic [7:0]        host_data_o,
  output logic              host_data_oe_o,
  output logic              host_req_o,
  input  logic              core_req_set_i,
  input  logic              core_req_clr_i,
  output logic [FLAT_W-1:0] core_regs_o,
  output logic [7:0]        core_vec_o
);
  localparam int unsigned N_STB = 2; // 0: enable, 1: acknowledge

  logic [N_STB-1:0] stb_raw, stb_lvl, stb_rise, stb_fall;
  assign stb_raw = {host_ack_ni, host_en_ni};

  for (genvar s = 0; s < N_STB; s++) begin : g_sync
    hp_strobe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(stb_raw[s]),
      .level_o(stb_lvl[s]),
      .rise_o (stb_rise[s]),
      .fall_o (stb_fall[s])
    );
  end

  cyc_e     cyc_w;
  logic     oe_w, wr_en_w, vec_done_w;
  hp_addr_t sel_addr_w, wr_addr_w;
  hp_data_t wr_data_w, rd_data_w, vec_w;
  logic     unused_lvl;
  assign unused_lvl = ^stb_lvl;

  hp_cycle_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_fall_i (stb_fall[0]),
    .en_rise_i (stb_rise[0]),
    .ack_fall_i(stb_fall[1]),
    .ack_rise_i(stb_rise[1]),
    .addr_i    (host_addr_i),
    .rnw_i     (host_rnw_i),
    .data_i    (host_data_i),
    .req_set_i (core_req_set_i),
    .req_clr_i (core_req_clr_i),
    .cyc_o     (cyc_w),
    .oe_o      (oe_w),
    .sel_addr_o(sel_addr_w),
    .wr_en_o   (wr_en_w),
    .wr_addr_o (wr_addr_w),
    .wr_data_o (wr_data_w),
    .vec_done_o(vec_done_w),
    .req_o     (host_req_o)
  );

  hp_reg_bank #(.NUM_GP(NUM_GP), .VEC_ADDR(VEC_ADDR), .VEC_RST(VEC_RST)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_w),
    .wr_addr_i(wr_addr_w),
    .wr_data_i(wr_data_w),
    .rd_addr_i(sel_addr_w),
    .rd_data_o(rd_data_w),
    .regs_o   (core_regs_o),
    .vec_o    (vec_w)
  );

  assign host_data_oe_o = oe_w;
  assign host_data_o    = !oe_w ? '0 : (cyc_w == CYC_VEC) ? vec_w : rd_data_w;
  assign core_vec_o     = vec_w;
endmodule

// File: rtl/hp_port_checker.sv
module hp_port_checker
  import host_port_pkg::*;
#(
  parameter int unsigned NUM_GP   = 5,
  parameter hp_addr_t    VEC_ADDR = 3'd7
) (
  input logic     clk_i,
  input logic     rst_ni,
  input cyc_e     cyc,
  input logic     oe,
  input hp_data_t data_o,
  input hp_data_t vec,
  input hp_addr_t sel_addr,
  input logic     en_rise,
  input logic     vec_done,
  input logic     req,
  input logic     req_set,
  input logic     req_clr
);
  assert_oe_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_rise && cyc == CYC_READ) |=> !oe);

  assert_no_write_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_WRITE) |-> !oe);

  assert_vec_on_bus_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe && cyc == CYC_VEC) |-> data_o == vec);

  assert_req_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_set && !req_clr && !vec_done) |=> req);

  assert_req_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_clr |=> !req);

  assert_req_ack_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_done |=> (!req && !oe));

  assert_unimpl_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe && cyc == CYC_READ && sel_addr >= hp_addr_t'(NUM_GP) && sel_addr != VEC_ADDR)
      |-> data_o == '0);
endmodule

bind host_reg_port hp_port_checker #(.NUM_GP(NUM_GP), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cyc     (cyc_w),
  .oe      (host_data_oe_o),
  .data_o  (host_data_o),
  .vec     (core_vec_o),
  .sel_addr(sel_addr_w),
  .en_rise (stb_rise[0]),
  .vec_done(vec_done_w),
  .req     (host_req_o),
  .req_set (core_req_set_i),
  .req_clr (core_req_clr_i)
);

// File: tb/host_reg_port_tb_top.sv
module host_reg_port_tb_top;
  import host_port_pkg::*;

  localparam int       NUM_GP   = 5;
  localparam hp_addr_t VEC_ADDR = 3'd7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] host_addr_i = '0;
  logic host_rnw_i = 1'b1, host_en_ni = 1'b1, host_ack_ni = 1'b1;
  logic [7:0] host_data_i = '0;
  logic [7:0] host_data_o;
  logic host_data_oe_o, host_req_o;
  logic core_req_set_i = 1'b0, core_req_clr_i = 1'b0;
  logic [NUM_GP*8-1:0] core_regs_o;
  logic [7:0] core_vec_o;

  always #4 clk_i = ~clk_i;

  host_reg_port dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0, live = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=0x%0h expected=0x%0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference model
  int   en_h[4], ack_h[4];
  logic [7:0] m_gp[NUM_GP];
  logic [7:0] m_vec;
  logic m_req, m_oe;
  cyc_e m_cyc;
  int   m_addr;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) begin en_h[i] = 1; ack_h[i] = 1; end
      for (int i = 0; i < NUM_GP; i++) m_gp[i] = 8'h00;
      m_vec = 8'h0F; m_req = 0; m_oe = 0; m_cyc = CYC_IDLE; m_addr = 0;
    end else begin
      bit ef, er, af, ar, vd;
      for (int i = 3; i > 0; i--) begin en_h[i] = en_h[i-1]; ack_h[i] = ack_h[i-1]; end
      en_h[0] = host_en_ni; ack_h[0] = host_ack_ni;
      ef = en_h[3] == 1 && en_h[2] == 0;  er = en_h[3] == 0 && en_h[2] == 1;
      af = ack_h[3] == 1 && ack_h[2] == 0; ar = ack_h[3] == 0 && ack_h[2] == 1;
      vd = 0;
      case (m_cyc)
        CYC_IDLE:
          if (af && m_req) begin m_cyc = CYC_VEC; m_oe = 1; end
          else if (ef) begin
            m_addr = int'(host_addr_i);
            m_cyc  = host_rnw_i ? CYC_READ : CYC_WRITE;
            m_oe   = host_rnw_i;
          end
        CYC_READ:  if (er) begin m_cyc = CYC_IDLE; m_oe = 0; end
        CYC_WRITE: if (er) begin
          if (m_addr < NUM_GP) m_gp[m_addr] = host_data_i;
          else if (m_addr == int'(VEC_ADDR)) m_vec = host_data_i;
          m_cyc = CYC_IDLE;
        end
        CYC_VEC: if (ar) begin m_cyc = CYC_IDLE; m_oe = 0; vd = 1; end
        default: m_cyc = CYC_IDLE;
      endcase
      m_req = (m_req | core_req_set_i) & ~(core_req_clr_i | vd);
    end
  end

  function automatic int exp_data();
    if (!m_oe) return 0;
    if (m_cyc == CYC_VEC) return int'(m_vec);
    if (m_addr < NUM_GP) return int'(m_gp[m_addr]);
    if (m_addr == int'(VEC_ADDR)) return int'(m_vec);
    return 0;
  endfunction

  function automatic string data_tag();
    if (m_cyc == CYC_VEC) return "R6";
    if (m_addr == int'(VEC_ADDR)) return "R5";
    if (m_addr >= NUM_GP) return "R9";
    return m_oe ? "R3" : "R4";
  endfunction

  always @(negedge clk_i) begin
    if (live && rst_ni) begin
      chk(m_cyc == CYC_VEC ? "R6" : "R4", int'(host_data_oe_o), int'(m_oe));
      chk(data_tag(), int'(host_data_o), exp_data());
      chk("R7", int'(host_req_o), int'(m_req));
      for (int i = 0; i < NUM_GP; i++)
        chk("R2", int'(core_regs_o[i*8 +: 8]), int'(m_gp[i]));
      chk("R5", int'(core_vec_o), int'(m_vec));
    end
  end

  task automatic host_access(bit rnw, logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    host_addr_i = a; host_rnw_i = rnw; host_data_i = d; host_en_ni = 0;
    repeat (5) @(negedge clk_i);
    host_en_ni = 1;
    repeat (5) @(negedge clk_i);
  endtask

  task automatic ack_cycle();
    @(negedge clk_i); host_ack_ni = 0;
    repeat (5) @(negedge clk_i); host_ack_ni = 1;
    repeat (5) @(negedge clk_i);
  endtask

  task automatic core_pulse(bit s, bit c);
    @(negedge clk_i); core_req_set_i = s; core_req_clr_i = c;
    @(negedge clk_i); core_req_set_i = 0; core_req_clr_i = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", int'(host_data_oe_o), 0);
    chk("R1", int'(host_req_o), 0);
    chk("R1", int'(core_regs_o), 0);
    chk("R1", int'(core_vec_o), 8'h0F);
    live = 1;

    // R2/R3 distinct patterns in the general registers
    for (int i = 0; i < NUM_GP; i++) host_access(0, 3'(i), 8'(8'h11 * (i + 1) ^ 8'hA0));
    // R9 unimplemented writes ignored
    host_access(0, 3'd5, 8'hFF);
    host_access(0, 3'd6, 8'h77);
    for (int i = 0; i < 8; i++) host_access(1, 3'(i), 8'h00);

    // R6/R8 vector cycle with reset vector
    core_pulse(1, 0);
    chk("R7", int'(host_req_o), 1);
    ack_cycle();
    chk("R8", int'(host_req_o), 0);

    // R10 acknowledge without request
    @(negedge clk_i); host_ack_ni = 0;
    repeat (4) @(negedge clk_i);
    chk("R10", int'(host_data_oe_o), 0);
    host_ack_ni = 1;
    repeat (5) @(negedge clk_i);

    // R5 rewrite vector register and read back
    host_access(0, VEC_ADDR, 8'hA5);
    host_access(1, VEC_ADDR, 8'h00);

    // R7 clear wins over set
    core_pulse(1, 1);
    chk("R7", int'(host_req_o), 0);
    core_pulse(1, 0);
    core_pulse(0, 1);
    chk("R7", int'(host_req_o), 0);

    // R6 vector cycle with new vector, then overwrite a register
    core_pulse(1, 0);
    ack_cycle();
    chk("R8", int'(host_req_o), 0);
    host_access(0, 3'd2, 8'h3C);
    host_access(1, 3'd2, 8'h00);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired t=%0t actual=hung expected=done", $time);
      summary();
      $finish;
    end
  end
endmodule